// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog that software programs through one byte-wide control register. Bits 6:2 of that register hold a multiplier, and bits 1:0 hold a resolution. The resolution picks a power of four. The timeout equals multiplier × 4^resolution periods of a 16 Hz time base, which the block receives as a one-cycle enable. A write to the control register restarts the countdown from the full interval. A read of the control register also restarts it, using the value already stored. A zero interval turns the watchdog off.

When the countdown runs out, the block sets an expiry flag. Bit 7 of the control register then selects one of two actions:

- **Bit 7 set:** the block raises a one-cycle system reset request. It also clears the control register and clears bit 6 of a companion byte register.
- **Bit 7 clear:** the block raises a one-cycle interrupt and leaves the control register unchanged.

Register selector encoding:

- 0: watchdog control
- 1: status flags
- 2: companion byte
- 3: reads 0x00, and writes to it are ignored

Top module: `sixteenth_watchdog`

## Requirements
- R1: Once reset is released, the control register, the status flags register and the companion byte register all read 0x00, and neither output is asserted.
- R2: After a restart, the block expires on exactly the Nth time-base enable, where N = bits 6:2 × 4^(bits 1:0) of the control value. It does not expire before that enable.
- R3: A control value whose interval is zero disarms the watchdog. This covers the value 0 and any value with multiplier 0. A disarmed watchdog never expires.
- R4: A write to selector 0 stores all eight data bits and restarts the countdown from the interval of the written value.
- R5: A read of selector 0 returns the stored value and restarts the countdown from the interval of that stored value.
- R6: In the status flags register (selector 1), bit 7 is the expiry flag and bits 6:0 read 0. Expiry sets the flag. Any read or write of selector 0 clears it.
- R7: If control bit 7 is clear at expiry, the interrupt output pulses high for exactly one cycle. The reset request stays low, and the control register keeps its value.
- R8: If control bit 7 is set at expiry, the reset request pulses high for exactly one cycle. The interrupt stays low, the control register becomes 0x00, and bit 6 of the companion byte clears while its other bits are kept.
- R9: Writes to the status flags register have no effect.
- R10: After an expiry, further time-base enables produce no pulse until the next restart.
- R11: If a selector-0 access and a time-base enable arrive in the same cycle, the restart takes priority and no expiry happens in that cycle.
- R12: The companion byte (selector 2) stores and returns all eight bits written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 16 Hz time-base enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_sel_i | input | 2 | Register selector |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register (combinational) |
| wdog_irq_o | output | 1 | One-cycle expiry interrupt |
| wdog_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:

- The two expiry outputs are exclusive and each is only one cycle wide.
- A reset request coincides with a cleared control register and a raised flag.
- An interrupt coincides with a clear steering bit.
- A zero-interval restart leaves the watchdog disarmed.
- A disarmed watchdog stays silent.

Only the bench scenarios can show the following:

- The exact tick on which expiry lands for every one of the 128 interval codes.
- That a read restarts the count.
- That a restart wins over a simultaneous time-base enable.
- How the companion byte and the flags register look through the bus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_AUX  = 2'd2,
    SEL_NONE = 2'd3
  } wdog_sel_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [CNT_W-1:0]  ticks_o
);
  always_comb begin
    ticks_o = CNT_W'(mult_i) << {res_i, 1'b0};
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             armed_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             armed_q, armed_n;

  always_comb begin
    cnt_n    = cnt_q;
    armed_n  = armed_q;
    expire_o = 1'b0;
    if (load_i) begin
      cnt_n   = load_val_i;
      armed_n = |load_val_i;
    end else if (tick_i && armed_q) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_n    = '0;
        armed_n  = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STEER_BIT = DATA_W - 1,
  parameter int FLAG_BIT  = DATA_W - 1,
  parameter int AUX_CLR   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] restart_val_o,
  output logic              restart_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_n, aux_q, aux_n;
  logic              flag_q, flag_n, irq_q, irq_n, req_q, req_n;
  logic              ctrl_wr, ctrl_rd, aux_wr, steer_hit;

  assign ctrl_wr   = wr_i && (sel_i == SEL_CTRL);
  assign ctrl_rd   = rd_i && !wr_i && (sel_i == SEL_CTRL);
  assign aux_wr    = wr_i && (sel_i == SEL_AUX);
  assign steer_hit = expire_i && ctrl_q[STEER_BIT];

  assign restart_o     = ctrl_wr || ctrl_rd;
  assign restart_val_o = ctrl_wr ? wdata_i : ctrl_q;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_wr)        ctrl_n = wdata_i;
    else if (steer_hit) ctrl_n = '0;

    aux_n = aux_q;
    if (aux_wr)         aux_n = wdata_i;
    else if (steer_hit) aux_n[AUX_CLR] = 1'b0;

    flag_n = flag_q;
    if (restart_o)      flag_n = 1'b0;
    else if (expire_i)  flag_n = 1'b1;

    irq_n = expire_i && !ctrl_q[STEER_BIT];
    req_n = steer_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      aux_q  <= aux_n;
      flag_q <= flag_n;
      irq_q  <= irq_n;
      req_q  <= req_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_FLAG: rdata_o[FLAG_BIT] = flag_q;
      SEL_AUX:  rdata_o = aux_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/sixteenth_watchdog.sv
module sixteenth_watchdog #(
  parameter int DATA_W = 8,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_sel_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdog_irq_o,
  output logic              wdog_rst_req_o
);
  localparam int MULT_W = DATA_W - 1 - RES_W;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  logic              rst_n_int;
  logic              restart, expire, armed, exp_flag;
  logic [DATA_W-1:0] restart_val, ctrl_q;
  logic [CNT_W-1:0]  load_ticks;

  wdog_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .wr_i          (bus_wr_i),
    .rd_i          (bus_rd_i),
    .sel_i         (bus_sel_i),
    .wdata_i       (bus_wdata_i),
    .expire_i      (expire),
    .rdata_o       (bus_rdata_o),
    .ctrl_o        (ctrl_q),
    .restart_val_o (restart_val),
    .restart_o     (restart),
    .flag_o        (exp_flag),
    .irq_o         (wdog_irq_o),
    .rst_req_o     (wdog_rst_req_o)
  );

  wdog_interval #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_ivl (
    .mult_i  (restart_val[DATA_W-2:RES_W]),
    .res_i   (restart_val[RES_W-1:0]),
    .ticks_o (load_ticks)
  );

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (restart),
    .load_val_i (load_ticks),
    .tick_i     (tick_i),
    .armed_o    (armed),
    .expire_o   (expire)
  );
endmodule

// File: rtl/sixteenth_watchdog_chk.sv
module sixteenth_watchdog_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              rst_req,
  input logic              restart,
  input logic [CNT_W-1:0]  load_ticks,
  input logic              armed,
  input logic              flag,
  input logic [DATA_W-1:0] ctrl
);
  // R7
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8
  req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl == '0 && flag));
  // R7
  irq_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && !ctrl[DATA_W-1]));
  // R3
  zero_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && load_ticks == '0) |=> !armed);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !restart) |=> !(irq || rst_req));
  // R6
  restart_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !flag);
endmodule

bind sixteenth_watchdog sixteenth_watchdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (wdog_irq_o),
  .rst_req    (wdog_rst_req_o),
  .restart    (restart),
  .load_ticks (load_ticks),
  .armed      (armed),
  .flag       (exp_flag),
  .ctrl       (ctrl_q)
);

// File: tb/sixteenth_watchdog_tb.sv
module sixteenth_watchdog_tb;
  logic       clk, rst_n, tick, wr, rd;
  logic [1:0] sel;
  logic [7:0] wdata, rdata;
  logic       irq, rreq;
  int         n_chk, n_fail;

  sixteenth_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_sel_i(sel), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wdog_irq_o(irq), .wdog_rst_req_o(rreq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; sel = s;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_tick(output bit irq_s, output bit req_s);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; irq_s = irq; req_s = rreq;
  endtask

  task automatic run_ticks(input int n, output int pulses);
    bit a, b;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      do_tick(a, b);
      pulses += int'(a) + int'(b);
    end
  endtask

  task automatic main;
    logic [7:0] d;
    bit a, b;
    int p, n;
    tick = 0; wr = 0; rd = 0; sel = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(irq == 0 && rreq == 0, "R1 outputs", {irq, rreq}, 0);
    bus_read(2'd0, d); check(d == 8'h00, "R1 ctrl", d, 0);
    bus_read(2'd1, d); check(d == 8'h00, "R1 flags", d, 0);
    bus_read(2'd2, d); check(d == 8'h00, "R1 aux", d, 0);

    // R12 aux byte, selector 3 reads zero
    bus_write(2'd2, 8'hA5); bus_read(2'd2, d); check(d == 8'hA5, "R12 aux", d, 8'hA5);
    bus_write(2'd3, 8'h77); bus_read(2'd3, d); check(d == 8'h00, "R12 sel3", d, 0);

    // R2 R3 R4 R6 R7: sweep all interrupt-steered codes
    for (int v = 0; v < 128; v++) begin
      n = (v >> 2) * (1 << (2 * (v & 3)));
      bus_write(2'd0, 8'(v));
      if (n == 0) begin
        run_ticks(4, p);
        check(p == 0, "R3 zero interval", p, 0);
        bus_read(2'd1, d); check(d == 8'h00, "R3 flag", d, 0);
      end else begin
        run_ticks(n - 1, p);
        check(p == 0, "R2 early expiry", p, 0);
        do_tick(a, b);
        check(a && !b, "R7 irq at expiry", {a, b}, 2'b10);
        bus_read(2'd1, d); check(d == 8'h80, "R6 flag set", d, 8'h80);
        bus_read(2'd0, d); check(d == 8'(v), "R4 R7 ctrl kept", d, v);
      end
    end

    // R10 no further pulse after expiry
    bus_write(2'd0, 8'h04);
    do_tick(a, b); check(a, "R10 setup", a, 1);
    run_ticks(8, p); check(p == 0, "R10 idle", p, 0);
    // R9 flags write ignored
    bus_write(2'd1, 8'h00); bus_read(2'd1, d); check(d == 8'h80, "R9 flags kept", d, 8'h80);
    // R5 R6 read restarts and clears flag
    bus_read(2'd0, d); bus_read(2'd1, d); check(d == 8'h00, "R6 read clears", d, 0);
    bus_write(2'd1, 8'hFF); bus_read(2'd1, d); check(d == 8'h00, "R9 flags write", d, 0);
    bus_write(2'd0, 8'h0C);
    run_ticks(2, p);
    bus_read(2'd0, d);
    run_ticks(2, p); check(p == 0, "R5 restart by read", p, 0);
    do_tick(a, b); check(a, "R5 expiry after read", a, 1);

    // R11 restart wins over same-cycle tick
    bus_write(2'd0, 8'h04);
    @(negedge clk); tick = 1; wr = 1; sel = 2'd0; wdata = 8'h08;
    @(negedge clk); tick = 0; wr = 0;
    check(!irq, "R11 no expiry on restart", irq, 0);
    do_tick(a, b); check(!a, "R11 first tick", a, 0);
    do_tick(a, b); check(a, "R11 second tick", a, 1);

    // R8 reset steering
    bus_write(2'd2, 8'hFF);
    bus_write(2'd0, 8'h88);
    do_tick(a, b); check(!a && !b, "R8 early", {a, b}, 0);
    do_tick(a, b); check(b && !a, "R8 request", {a, b}, 2'b01);
    @(negedge clk); check(!rreq, "R8 one cycle", rreq, 0);
    bus_read(2'd1, d); check(d == 8'h80, "R8 flag", d, 8'h80);
    bus_read(2'd2, d); check(d == 8'hBF, "R8 aux bit6", d, 8'hBF);
    bus_read(2'd0, d); check(d == 8'h00, "R8 ctrl cleared", d, 0);
    run_ticks(6, p); check(p == 0, "R8 R10 quiet after", p, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    fork
      main();
      begin
        repeat (195000) @(posedge clk);
        check(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule